// File: doc/BRIEF.md
# Snoop Request and Flush Handshake Unit

This unit sits on the memory-bus-controller side of a second-level cache and runs the synchronous snoop handshake with that cache. When a memory cycle from another bus master is observed, the unit latches the cycle's address and its invalidate and no-allocate qualifiers. It computes an even parity bit over the line-address bits and chooses where the writeback that may follow should begin. It then strobes a snoop into the cache. The unit does not issue a snoop while the local cache itself drives the address bus, because that cycle belongs to the local cache and only the other caches snoop it.

The cache answers with a hit result. If that result says hit-modified, the cache later raises a writeback strobe. The unit forwards the hit result to the system. For a hit-modified line it raises a writeback service request that carries the burst length: a full line of 4 or 8 memory transfers, and no transfers to the processor. Only one snoop may be outstanding at a time.

The unit also sequences flush and writeback special cycles from the processor. It raises the cache's flush input and holds back the processor ready until the cache acknowledges with its address-hold output. It then reports completion once the cache's flush-in-progress output goes low. Any other special cycle is completed at once.

Top module: `snoop_flush_ctrl`

## Requirements
- R1: One cycle after an observed cycle is accepted (bus_valid high, local_drive low, snp_busy low), snp_start pulses for one cycle, and snp_addr, snp_inv and snp_nca hold the values sampled with it.
- R2: snp_par is chosen so that snp_addr[ADDR_W-1:LINE_OFF_W] together with snp_par contains an even number of ones.
- R3: While local_drive is high, an observed cycle issues no snoop: snp_start stays low and snp_busy stays low.
- R4: wb_sub is 0 when bus_sub0 was high at acceptance; otherwise it equals the sub-line field bus_addr[LINE_OFF_W-1:LINE_OFF_W-SUB_W] sampled at acceptance.
- R5: One cycle after cache_hit_valid is sampled while a snoop is outstanding, sys_hit_valid pulses and sys_hitm carries cache_hitm. snp_busy drops at that same edge.
- R6: One cycle after cache_wb_strobe is sampled following a hit-modified result, wb_req pulses with wb_beats equal to 8 when cfg_line8 is 1 and 4 when it is 0. A strobe after a clean hit result produces no wb_req.
- R7: snp_busy is high from acceptance until the hit result is sampled. A bus_valid seen while it is high starts no snoop and leaves snp_addr unchanged.
- R8: For spc_code 2'b01 (flush) or 2'b10 (writeback), cache_flush rises one cycle after spc_valid and stays high until cache_hold is sampled. cpu_ready pulses exactly one cycle after that sample and never earlier.
- R9: For spc_code 2'b00 or 2'b11, cpu_ready pulses one cycle after spc_valid and cache_flush stays low.
- R10: After cache_hold is seen, flush_done pulses one cycle after flush_busy is sampled low, provided flush_busy has been seen high since the hold. It stays low before that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_line8 | input | 1 | Cache line is 8 memory transfers (1) or 4 (0) |
| bus_valid | input | 1 | Observed memory cycle from another master |
| bus_addr | input | ADDR_W | Address of the observed cycle |
| bus_inv | input | 1 | Observed cycle requests invalidation |
| bus_nca | input | 1 | Observed cycle requests no cache allocation |
| bus_sub0 | input | 1 | Writeback should start at sub-line 0 |
| local_drive | input | 1 | Local cache is driving the address bus |
| snp_start | output | 1 | Snoop strobe to the cache |
| snp_addr | output | ADDR_W | Latched snoop address |
| snp_par | output | 1 | Even parity over the line-address bits |
| snp_inv | output | 1 | Latched invalidate request |
| snp_nca | output | 1 | Latched no-allocate request |
| wb_sub | output | SUB_W | Start sub-line for a resulting writeback |
| snp_busy | output | 1 | Snoop outstanding, hit result not yet sampled |
| cache_hit_valid | input | 1 | Cache hit result is valid |
| cache_hitm | input | 1 | Cache hit result is hit-modified |
| cache_wb_strobe | input | 1 | Cache starts the snoop writeback |
| sys_hit_valid | output | 1 | Forwarded hit result is valid |
| sys_hitm | output | 1 | Forwarded hit-modified flag |
| wb_req | output | 1 | Snoop writeback must be serviced now |
| wb_beats | output | 4 | Memory transfers for the writeback |
| spc_valid | input | 1 | Processor special cycle decoded |
| spc_code | input | 2 | Special cycle kind |
| cache_hold | input | 1 | Cache address-hold output |
| flush_busy | input | 1 | Cache flush in progress |
| cache_flush | output | 1 | Flush request to the cache |
| cpu_ready | output | 1 | Ready to the processor for the special cycle |
| flush_done | output | 1 | Flush operation complete |

## Verification
Every output is a register one edge behind the input event that causes it: snp_start, the latched fields and snp_busy follow the accepted bus cycle by one cycle. The forwarded hit result follows cache_hit_valid by one cycle, and wb_req follows the writeback strobe by one cycle. cache_flush, cpu_ready and flush_done follow spc_valid, cache_hold and the falling flush_busy by one cycle each. The bench drives each input on the falling edge, samples one nanosecond after the next rising edge, and at each step also checks that no output has moved early. Parity and the sub-line choice are checked against a bench-side bit count for random addresses, and the flush handshake is checked with several hold and busy delays.

// File: rtl/snf_pkg.sv
package snf_pkg;

  typedef enum logic [1:0] {
    SPC_MISC0 = 2'b00,
    SPC_FLUSH = 2'b01,
    SPC_WBACK = 2'b10,
    SPC_MISC3 = 2'b11
  } spc_code_e;

  typedef enum logic [1:0] {
    FL_IDLE   = 2'd0,
    FL_ASSERT = 2'd1,
    FL_RUN    = 2'd2
  } fl_state_e;

  // XOR of all bits: the bit that makes the vector plus itself even.
  function automatic logic even_parity(input logic [63:0] v);
    return ^v;
  endfunction

  // Memory transfers in one cache line.
  function automatic logic [3:0] line_beats(input logic line8);
    return line8 ? 4'd8 : 4'd4;
  endfunction

  // Flush-class special cycles need the cache handshake.
  function automatic logic is_flush_code(input logic [1:0] code);
    return (code == SPC_FLUSH) || (code == SPC_WBACK);
  endfunction

endpackage

// File: rtl/snoop_capture.sv
module snoop_capture
  import snf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_OFF_W = 5,
  parameter int SUB_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_inv,
  input  logic              bus_nca,
  input  logic              bus_sub0,
  output logic              snp_start,
  output logic [ADDR_W-1:0] snp_addr,
  output logic              snp_par,
  output logic              snp_inv,
  output logic              snp_nca,
  output logic [SUB_W-1:0]  wb_sub
);
  localparam int LINE_W = ADDR_W - LINE_OFF_W;
  localparam int SUB_LO = LINE_OFF_W - SUB_W;

  logic [63:0]      line_bits;
  logic             par_next;
  logic [SUB_W-1:0] sub_next;

  always_comb begin
    line_bits = '0;
    line_bits[LINE_W-1:0] = bus_addr[ADDR_W-1:LINE_OFF_W];
    par_next  = even_parity(line_bits);
    sub_next  = bus_sub0 ? '0 : bus_addr[SUB_LO +: SUB_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snp_start <= 1'b0;
      snp_addr  <= '0;
      snp_par   <= 1'b0;
      snp_inv   <= 1'b0;
      snp_nca   <= 1'b0;
      wb_sub    <= '0;
    end else begin
      snp_start <= accept;
      if (accept) begin
        snp_addr <= bus_addr;
        snp_par  <= par_next;
        snp_inv  <= bus_inv;
        snp_nca  <= bus_nca;
        wb_sub   <= sub_next;
      end
    end
  end

  AST_PARITY_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    snp_start |-> (($countones({snp_addr[ADDR_W-1:LINE_OFF_W], snp_par}) % 2) == 0)); // R2

  AST_SUB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_start && $past(bus_sub0)) |-> (wb_sub == '0)); // R4

  AST_FIELDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(snp_addr)); // R7

endmodule

// File: rtl/snoop_resp.sv
module snoop_resp
  import snf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic       cfg_line8,
  input  logic       cache_hit_valid,
  input  logic       cache_hitm,
  input  logic       cache_wb_strobe,
  output logic       busy,
  output logic       sys_hit_valid,
  output logic       sys_hitm,
  output logic       wb_req,
  output logic [3:0] wb_beats
);
  logic wb_pend;
  logic hit_take;
  logic wb_take;

  assign hit_take = busy && cache_hit_valid;
  assign wb_take  = wb_pend && cache_wb_strobe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy          <= 1'b0;
      sys_hit_valid <= 1'b0;
      sys_hitm      <= 1'b0;
      wb_pend       <= 1'b0;
      wb_req        <= 1'b0;
      wb_beats      <= '0;
    end else begin
      sys_hit_valid <= hit_take;
      wb_req        <= wb_take;
      if (accept)
        busy <= 1'b1;
      else if (hit_take)
        busy <= 1'b0;
      if (hit_take)
        sys_hitm <= cache_hitm;
      wb_pend <= (wb_pend && !wb_take) || (hit_take && cache_hitm);
      if (wb_take)
        wb_beats <= line_beats(cfg_line8);
    end
  end

  AST_HIT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    sys_hit_valid |-> $past(busy)); // R5

  AST_BUSY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sys_hit_valid |-> !busy); // R5

  AST_WB_NEEDS_HITM: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> $past(wb_pend)); // R6

  AST_WB_BEATS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> (wb_beats == 4'd4 || wb_beats == 4'd8)); // R6

endmodule

// File: rtl/flush_seq.sv
module flush_seq
  import snf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spc_valid,
  input  logic [1:0] spc_code,
  input  logic       cache_hold,
  input  logic       flush_busy,
  output logic       cache_flush,
  output logic       cpu_ready,
  output logic       flush_done
);
  fl_state_e st;
  logic      seen_busy;
  logic      flush_decode;
  logic      misc_decode;
  logic      hold_seen;

  assign flush_decode = (st == FL_IDLE) && spc_valid && is_flush_code(spc_code);
  assign misc_decode  = (st == FL_IDLE) && spc_valid && !is_flush_code(spc_code);
  assign hold_seen    = (st == FL_ASSERT) && cache_hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= FL_IDLE;
      seen_busy   <= 1'b0;
      cache_flush <= 1'b0;
      cpu_ready   <= 1'b0;
      flush_done  <= 1'b0;
    end else begin
      cpu_ready  <= 1'b0;
      flush_done <= 1'b0;
      case (st)
        FL_IDLE: begin
          if (flush_decode) begin
            cache_flush <= 1'b1;
            st          <= FL_ASSERT;
          end else if (misc_decode) begin
            cpu_ready <= 1'b1;
          end
        end
        FL_ASSERT: begin
          if (hold_seen) begin
            cache_flush <= 1'b0;
            cpu_ready   <= 1'b1;
            seen_busy   <= flush_busy;
            st          <= FL_RUN;
          end
        end
        FL_RUN: begin
          if (flush_busy) begin
            seen_busy <= 1'b1;
          end else if (seen_busy) begin
            flush_done <= 1'b1;
            seen_busy  <= 1'b0;
            st         <= FL_IDLE;
          end
        end
        default: st <= FL_IDLE;
      endcase
    end
  end

  AST_FLUSH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cache_flush && !cache_hold) |=> cache_flush); // R8

  AST_READY_WITH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cache_flush) |-> cpu_ready); // R8

  AST_NO_READY_WHILE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    cache_flush |-> !cpu_ready); // R8

  AST_DONE_ON_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |-> !$past(flush_busy)); // R10

endmodule

// File: rtl/snoop_flush_ctrl.sv
module snoop_flush_ctrl
  import snf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_OFF_W = 5,
  parameter int SUB_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_line8,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_inv,
  input  logic              bus_nca,
  input  logic              bus_sub0,
  input  logic              local_drive,
  output logic              snp_start,
  output logic [ADDR_W-1:0] snp_addr,
  output logic              snp_par,
  output logic              snp_inv,
  output logic              snp_nca,
  output logic [SUB_W-1:0]  wb_sub,
  output logic              snp_busy,
  input  logic              cache_hit_valid,
  input  logic              cache_hitm,
  input  logic              cache_wb_strobe,
  output logic              sys_hit_valid,
  output logic              sys_hitm,
  output logic              wb_req,
  output logic [3:0]        wb_beats,
  input  logic              spc_valid,
  input  logic [1:0]        spc_code,
  input  logic              cache_hold,
  input  logic              flush_busy,
  output logic              cache_flush,
  output logic              cpu_ready,
  output logic              flush_done
);
  logic snoop_accept;

  assign snoop_accept = bus_valid && !local_drive && !snp_busy;

  snoop_capture #(
    .ADDR_W(ADDR_W), .LINE_OFF_W(LINE_OFF_W), .SUB_W(SUB_W)
  ) u_capture (
    .clk(clk), .rst_n(rst_n), .accept(snoop_accept),
    .bus_addr(bus_addr), .bus_inv(bus_inv), .bus_nca(bus_nca), .bus_sub0(bus_sub0),
    .snp_start(snp_start), .snp_addr(snp_addr), .snp_par(snp_par),
    .snp_inv(snp_inv), .snp_nca(snp_nca), .wb_sub(wb_sub)
  );

  snoop_resp u_resp (
    .clk(clk), .rst_n(rst_n), .accept(snoop_accept), .cfg_line8(cfg_line8),
    .cache_hit_valid(cache_hit_valid), .cache_hitm(cache_hitm),
    .cache_wb_strobe(cache_wb_strobe), .busy(snp_busy),
    .sys_hit_valid(sys_hit_valid), .sys_hitm(sys_hitm),
    .wb_req(wb_req), .wb_beats(wb_beats)
  );

  flush_seq u_flush (
    .clk(clk), .rst_n(rst_n), .spc_valid(spc_valid), .spc_code(spc_code),
    .cache_hold(cache_hold), .flush_busy(flush_busy),
    .cache_flush(cache_flush), .cpu_ready(cpu_ready), .flush_done(flush_done)
  );

  AST_NO_SELF_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
    local_drive |=> !snp_start); // R3

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    snp_start |-> !$past(snp_busy)); // R7

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    snp_start |-> snp_busy); // R1

endmodule

// File: tb/test_snoop_flush_ctrl.sv
module test_snoop_flush_ctrl;
  localparam int ADDR_W = 32;
  localparam int LOFF   = 5;
  localparam int SUB_W  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_line8 = 1'b0;
  logic bus_valid = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic bus_inv = 1'b0, bus_nca = 1'b0, bus_sub0 = 1'b0, local_drive = 1'b0;
  logic snp_start, snp_par, snp_inv, snp_nca, snp_busy;
  logic [ADDR_W-1:0] snp_addr;
  logic [SUB_W-1:0] wb_sub;
  logic cache_hit_valid = 1'b0, cache_hitm = 1'b0, cache_wb_strobe = 1'b0;
  logic sys_hit_valid, sys_hitm, wb_req;
  logic [3:0] wb_beats;
  logic spc_valid = 1'b0;
  logic [1:0] spc_code = 2'b00;
  logic cache_hold = 1'b0, flush_busy = 1'b0;
  logic cache_flush, cpu_ready, flush_done;

  int n_vec = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  snoop_flush_ctrl #(.ADDR_W(ADDR_W), .LINE_OFF_W(LOFF), .SUB_W(SUB_W)) i_snoop_flush_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_line8(cfg_line8), .bus_valid(bus_valid),
    .bus_addr(bus_addr), .bus_inv(bus_inv), .bus_nca(bus_nca), .bus_sub0(bus_sub0),
    .local_drive(local_drive), .snp_start(snp_start), .snp_addr(snp_addr),
    .snp_par(snp_par), .snp_inv(snp_inv), .snp_nca(snp_nca), .wb_sub(wb_sub),
    .snp_busy(snp_busy), .cache_hit_valid(cache_hit_valid), .cache_hitm(cache_hitm),
    .cache_wb_strobe(cache_wb_strobe), .sys_hit_valid(sys_hit_valid),
    .sys_hitm(sys_hitm), .wb_req(wb_req), .wb_beats(wb_beats),
    .spc_valid(spc_valid), .spc_code(spc_code), .cache_hold(cache_hold),
    .flush_busy(flush_busy), .cache_flush(cache_flush), .cpu_ready(cpu_ready),
    .flush_done(flush_done)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Parity bit that makes the line-address bits even, by counting ones.
  function automatic logic exp_par(input logic [ADDR_W-1:0] a);
    int ones = 0;
    for (int i = LOFF; i < ADDR_W; i++) ones += a[i];
    return (ones % 2) == 1;
  endfunction

  function automatic logic [SUB_W-1:0] exp_sub(input logic [ADDR_W-1:0] a, input logic s0);
    if (s0) return '0;
    return SUB_W'((a >> (LOFF - SUB_W)) & ((1 << SUB_W) - 1));
  endfunction

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic do_snoop(input logic [ADDR_W-1:0] a, input logic inv, input logic nca,
                          input logic s0, input logic hitm, input logic l8);
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = a; bus_inv = inv; bus_nca = nca; bus_sub0 = s0;
    cfg_line8 = l8;
    tick();
    chk("R1 start", snp_start, 1);
    chk("R1 addr", snp_addr, a);
    chk("R1 inv/nca", {snp_inv, snp_nca}, {inv, nca});
    chk("R2 parity", snp_par, exp_par(a));
    chk("R4 sub", wb_sub, exp_sub(a, s0));
    chk("R7 busy", snp_busy, 1);
    // R7: a second observed cycle while busy is dropped
    @(negedge clk);
    bus_addr = ~a; bus_sub0 = 1'b0;
    tick();
    chk("R7 no restart", snp_start, 0);
    chk("R7 addr held", snp_addr, a);
    @(negedge clk);
    bus_valid = 1'b0; cache_hit_valid = 1'b1; cache_hitm = hitm;
    tick();
    chk("R5 hit valid", sys_hit_valid, 1);
    chk("R5 hitm", sys_hitm, hitm);
    chk("R5 busy clear", snp_busy, 0);
    chk("R6 no early wb", wb_req, 0);
    @(negedge clk);
    cache_hit_valid = 1'b0; cache_hitm = 1'b0; cache_wb_strobe = 1'b1;
    tick();
    chk("R6 wb_req", wb_req, hitm);
    if (hitm) chk("R6 beats", wb_beats, l8 ? 4'd8 : 4'd4);
    @(negedge clk);
    cache_wb_strobe = 1'b0;
    tick();
    chk("R6 wb pulse", wb_req, 0);
  endtask

  task automatic do_flush(input logic [1:0] code, input int hold_dly, input int busy_len);
    @(negedge clk);
    spc_valid = 1'b1; spc_code = code;
    tick();
    chk("R8 flush raised", cache_flush, 1);
    chk("R8 no early ready", cpu_ready, 0);
    @(negedge clk);
    spc_valid = 1'b0;
    for (int i = 0; i < hold_dly; i++) begin
      tick();
      chk("R8 wait hold", {cache_flush, cpu_ready}, 2'b10);
      @(negedge clk);
    end
    cache_hold = 1'b1; flush_busy = 1'b1;
    tick();
    chk("R8 ready after hold", cpu_ready, 1);
    chk("R8 flush dropped", cache_flush, 0);
    @(negedge clk);
    cache_hold = 1'b0;
    for (int i = 0; i < busy_len; i++) begin
      tick();
      chk("R10 not done", flush_done, 0);
      chk("R8 single ready", cpu_ready, 0);
      @(negedge clk);
    end
    flush_busy = 1'b0;
    tick();
    chk("R10 done", flush_done, 1);
    @(negedge clk);
    tick();
    chk("R10 done pulse", flush_done, 0);
  endtask

  task automatic do_misc(input logic [1:0] code);
    @(negedge clk);
    spc_valid = 1'b1; spc_code = code;
    tick();
    chk("R9 ready", cpu_ready, 1);
    chk("R9 no flush", cache_flush, 0);
    @(negedge clk);
    spc_valid = 1'b0;
    tick();
    chk("R9 ready pulse", cpu_ready, 0);
  endtask

  initial begin
    #400000;
    n_err++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset start", snp_start, 0);
    chk("R7 reset busy", snp_busy, 0);
    chk("R8 reset flush/ready", {cache_flush, cpu_ready, flush_done}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R3: self-snoop inhibit
    @(negedge clk);
    bus_valid = 1'b1; local_drive = 1'b1; bus_addr = 32'h1234_5678;
    tick();
    chk("R3 no snoop", snp_start, 0);
    chk("R3 not busy", snp_busy, 0);
    @(negedge clk);
    bus_valid = 1'b0; local_drive = 1'b0;

    // Directed corners
    do_snoop(32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    do_snoop(32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    do_snoop(32'hFFFF_FFF8, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    do_snoop(32'h0000_0020, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);

    // Random snoops
    for (int k = 0; k < 40; k++) begin
      logic [3:0] r;
      r = 4'($urandom);
      do_snoop($urandom, r[0], r[1], r[2], r[3], 1'($urandom));
    end

    // Flush handshake orderings
    do_flush(2'b01, 0, 1);
    do_flush(2'b10, 3, 2);
    do_flush(2'b01, 1, 4);
    do_misc(2'b00);
    do_misc(2'b11);
    do_flush(2'b10, 5, 0);

    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule